// File: doc/BRIEF.md
# Display RAM Address Controller

This block owns the host-side addressing of a bit-mapped display memory made of 8 pages. Each page holds 132 byte-wide columns, and each byte carries 8 vertically stacked pixels. Command bytes from the decoder set the page and the column and select the access modes. Data strobes from the host interface write bytes into the memory or read them back, and the column moves forward by itself after each access.

Reads pass through a one-byte holding register. A read therefore hands back the byte fetched by the read before it, so the host has to issue one throw-away read after it moves the column. A read-modify-write mode lets the host read a byte, change it and write it back without the column running away. Leaving the mode puts the column back where it stood on entry. A mirror option reverses the order of the physical columns so that a panel mounted the other way round still reads left to right.

The memory sits inside the block. Its port is brought out so the access stream can be observed.

Top module: `disp_ram_access`

## Requirements
- R1: After reset the column is 0, the page is 0, the mirror is off, read-modify-write is off, `rd_data` is 0x00 and neither `mem_we` nor `mem_re` is high.
- R2: A command in 0x00–0x0F replaces only the low nibble of the 8-bit column with bits 3:0 of the command. A command in 0x10–0x1F replaces only the high nibble with bits 3:0.
- R3: A command in 0xB0–0xB7 sets the page to bits 2:0. The page changes on no other event.
- R4: A write strobe at a legal column raises `mem_we` for exactly one cycle, starting the cycle after the strobe. During that cycle `mem_addr` = page × 132 + physical column, and the byte on `din` is stored there.
- R5: Each executed write or read moves the column up by one. Column 131 stays at 131: it does not wrap to column 0 or to the next page.
- R6: A read strobe at a legal column raises `mem_re` for one cycle, with the address formed as in R4. One cycle after that, `rd_data` takes the byte fetched by the previous executed read, or 0x00 if no read has been executed since reset. `rd_data` changes at no other time.
- R7: Command 0xE0 turns on read-modify-write mode and saves the current column. In this mode reads leave the column unchanged and writes still advance it.
- R8: Command 0xEE, while the mode is on, restores the saved column and turns the mode off. Outside the mode, 0xEE has no effect.
- R9: Command 0xA1 turns the mirror on, which makes the physical column 131 − column. Command 0xA0 turns it off, which makes the physical column equal the column.
- R10: A write or read strobe while the column is above 131 is ignored. No memory port pulse is raised, the column does not move and `rd_data` keeps its value.
- R11: Command codes other than those named in R2, R3 and R7–R9 leave the column, page, mirror and mode unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_stb | input | 1 | One-cycle pulse: `din` holds a command byte |
| wr_stb | input | 1 | One-cycle pulse: `din` holds a display byte to write |
| rd_stb | input | 1 | One-cycle pulse: read a display byte |
| din | input | 8 | Command or data byte |
| mem_addr | output | 11 | Flat memory address of the current access |
| mem_we | output | 1 | Memory write pulse |
| mem_re | output | 1 | Memory read pulse |
| rd_data | output | 8 | Byte returned to the host |

## Verification
The bench first reads straight after a column change and expects the stale byte, then expects each later read to lag one address behind. A design without the holding register would return the current byte and miss the dummy read. It drives the column into 131 with the mirror on and with it off. A counter that wraps would address column 0, or the far end of the mirror, on the next write. It runs read-modify-write with repeated reads, then with writes, then with a second End. A design that advances the column on reads, or that restores the column outside the mode, lands on the wrong address. Strobes at column 132 must leave the memory port quiet and `rd_data` unchanged. A design that checks only against the memory size would write out of range there.

// File: rtl/dram_pkg.sv
package dram_pkg;
  localparam int BYTE_W = 8;

  // Opcodes with a single fixed value
  localparam logic [BYTE_W-1:0] OPC_RMW_ENTER = 8'hE0;
  localparam logic [BYTE_W-1:0] OPC_RMW_LEAVE = 8'hEE;

  // Decoded command actions; at most one field is set per command
  typedef struct packed {
    logic col_lo;
    logic col_hi;
    logic page;
    logic mirror;
    logic rmw_on;
    logic rmw_off;
  } dram_op_t;
endpackage

// File: rtl/dram_cmd_dec.sv
module dram_cmd_dec
  import dram_pkg::*;
#(
  parameter int PAGES = 8
) (
  input  logic [BYTE_W-1:0] code,
  output dram_op_t          op
);
  always_comb begin
    op         = '0;
    op.col_lo  = (code[7:4] == 4'h0);
    op.col_hi  = (code[7:4] == 4'h1);
    op.page    = (code[7:4] == 4'hB) && (int'(code[3:0]) < PAGES);
    op.mirror  = (code[7:1] == 7'b1010_000);
    op.rmw_on  = (code == OPC_RMW_ENTER);
    op.rmw_off = (code == OPC_RMW_LEAVE);
  end
endmodule

// File: rtl/dram_addr_ctl.sv
module dram_addr_ctl
  import dram_pkg::*;
#(
  parameter int COLS   = 132,
  parameter int PAGES  = 8,
  parameter bit MIRROR = 1'b1,
  localparam int DEPTH = COLS * PAGES,
  localparam int AW    = $clog2(DEPTH),
  localparam int PW    = $clog2(PAGES),
  localparam int CW    = BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_stb,
  input  logic              wr_stb,
  input  logic              rd_stb,
  input  logic [BYTE_W-1:0] din,
  input  dram_op_t          op,
  output logic [AW-1:0]     mem_addr,
  output logic              mem_we,
  output logic              mem_re,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic [CW-1:0]     col_q,
  output logic [PW-1:0]     page_q,
  output logic              rmw_q,
  output logic [CW-1:0]     saved_q
);
  localparam logic [CW-1:0] LAST = CW'(COLS - 1);

  logic          remap_q;
  logic          in_range;
  logic          do_wr;
  logic          do_rd;
  logic [CW-1:0] phys;
  logic [CW-1:0] col_next;
  logic [AW-1:0] flat;

  // Commands take priority over data strobes, and writes over reads
  assign in_range = (col_q <= LAST);
  assign do_wr    = wr_stb && !cmd_stb && in_range;
  assign do_rd    = rd_stb && !cmd_stb && !wr_stb && in_range;
  assign col_next = (col_q == LAST) ? col_q : col_q + 1'b1;

  generate
    if (MIRROR) begin : g_mirror
      assign phys = remap_q ? (LAST - col_q) : col_q;
    end else begin : g_plain
      assign phys = col_q;
    end
  endgenerate

  assign flat = AW'(page_q) * AW'(COLS) + AW'(phys);

  always_ff @(posedge clk) begin
    if (rst) begin
      col_q     <= '0;
      page_q    <= '0;
      remap_q   <= 1'b0;
      rmw_q     <= 1'b0;
      saved_q   <= '0;
      mem_addr  <= '0;
      mem_we    <= 1'b0;
      mem_re    <= 1'b0;
      mem_wdata <= '0;
    end else begin
      mem_we <= do_wr;
      mem_re <= do_rd;
      if (do_wr || do_rd) mem_addr <= flat;
      if (do_wr) mem_wdata <= din;

      if (cmd_stb) begin
        if (op.col_lo) col_q <= {col_q[CW-1:4], din[3:0]};
        if (op.col_hi) col_q <= {din[3:0], col_q[3:0]};
        if (op.page)   page_q <= din[PW-1:0];
        if (op.mirror) remap_q <= din[0];
        if (op.rmw_on) begin
          rmw_q   <= 1'b1;
          saved_q <= col_q;
        end
        if (op.rmw_off && rmw_q) begin
          rmw_q <= 1'b0;
          col_q <= saved_q;
        end
      end else if (do_wr) begin
        col_q <= col_next;
      end else if (do_rd && !rmw_q) begin
        col_q <= col_next;
      end
    end
  end
endmodule

// File: rtl/dram_store.sv
module dram_store
  import dram_pkg::*;
#(
  parameter int DEPTH = 1056,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              re,
  input  logic [AW-1:0]     addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rd_data
);
  logic [BYTE_W-1:0] mem [DEPTH];
  logic [BYTE_W-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  // The read register doubles as the host-side holding latch
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q  <= '0;
      rd_data <= '0;
    end else if (re) begin
      hold_q  <= mem[addr];
      rd_data <= hold_q;
    end
  end
endmodule

// File: rtl/disp_ram_access.sv
module disp_ram_access
  import dram_pkg::*;
#(
  parameter int COLS   = 132,
  parameter int PAGES  = 8,
  parameter bit MIRROR = 1'b1,
  localparam int DEPTH = COLS * PAGES,
  localparam int AW    = $clog2(DEPTH),
  localparam int PW    = $clog2(PAGES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_stb,
  input  logic              wr_stb,
  input  logic              rd_stb,
  input  logic [BYTE_W-1:0] din,
  output logic [AW-1:0]     mem_addr,
  output logic              mem_we,
  output logic              mem_re,
  output logic [BYTE_W-1:0] rd_data
);
  dram_op_t          op;
  logic [BYTE_W-1:0] mem_wdata;
  logic [BYTE_W-1:0] col_q;
  logic [BYTE_W-1:0] saved_q;
  logic [PW-1:0]     page_q;
  logic              rmw_q;

  dram_cmd_dec #(.PAGES(PAGES)) dec_i (
    .code (din),
    .op   (op)
  );

  dram_addr_ctl #(.COLS(COLS), .PAGES(PAGES), .MIRROR(MIRROR)) ctl_i (
    .clk       (clk),
    .rst       (rst),
    .cmd_stb   (cmd_stb),
    .wr_stb    (wr_stb),
    .rd_stb    (rd_stb),
    .din       (din),
    .op        (op),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .mem_wdata (mem_wdata),
    .col_q     (col_q),
    .page_q    (page_q),
    .rmw_q     (rmw_q),
    .saved_q   (saved_q)
  );

  dram_store #(.DEPTH(DEPTH)) store_i (
    .clk     (clk),
    .rst     (rst),
    .we      (mem_we),
    .re      (mem_re),
    .addr    (mem_addr),
    .wdata   (mem_wdata),
    .rd_data (rd_data)
  );
endmodule

// File: rtl/dram_chk.sv
module dram_chk #(
  parameter int COLS = 132,
  parameter int PW   = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          cmd_stb,
  input logic          wr_stb,
  input logic          rd_stb,
  input logic [7:0]    din,
  input logic          mem_we,
  input logic          mem_re,
  input logic [7:0]    rd_data,
  input logic [7:0]    col_q,
  input logic [PW-1:0] page_q,
  input logic          rmw_q,
  input logic [7:0]    saved_q
);
  localparam logic [7:0] LAST = 8'(COLS - 1);

  assert_we_from_strobe_R4: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> ($past(wr_stb) && !$past(cmd_stb)));

  assert_rd_moves_on_read_R6: assert property (@(posedge clk) disable iff (rst)
    !$stable(rd_data) |-> $past(mem_re));

  assert_col_step_R5: assert property (@(posedge clk) disable iff (rst)
    !$past(cmd_stb) |-> (col_q == $past(col_q) || col_q == $past(col_q) + 8'd1));

  assert_col_saturate_R5: assert property (@(posedge clk) disable iff (rst)
    ($past(col_q) == LAST && !$past(cmd_stb)) |-> (col_q == LAST));

  assert_page_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !$past(cmd_stb) |-> $stable(page_q));

  assert_rmw_read_hold_R7: assert property (@(posedge clk) disable iff (rst)
    $past(rd_stb && !wr_stb && !cmd_stb && rmw_q) |-> $stable(col_q));

  assert_end_restore_R8: assert property (@(posedge clk) disable iff (rst)
    $past(cmd_stb && din == 8'hEE && rmw_q) |-> (col_q == $past(saved_q) && !rmw_q));

  assert_out_of_range_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    (!cmd_stb && (wr_stb || rd_stb) && col_q > LAST) |=> !(mem_we || mem_re));
endmodule

bind disp_ram_access dram_chk #(.COLS(COLS), .PW(PW)) chk_i (
  .clk     (clk),
  .rst     (rst),
  .cmd_stb (cmd_stb),
  .wr_stb  (wr_stb),
  .rd_stb  (rd_stb),
  .din     (din),
  .mem_we  (mem_we),
  .mem_re  (mem_re),
  .rd_data (rd_data),
  .col_q   (col_q),
  .page_q  (page_q),
  .rmw_q   (rmw_q),
  .saved_q (saved_q)
);

// File: tb/disp_ram_access_tb.sv
module disp_ram_access_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 57;

  localparam logic [1:0] K_CMD = 2'd0, K_WR = 2'd1, K_RD = 2'd2;
  localparam logic [1:0] C_NONE = 2'd0, C_ACC = 2'd1, C_DAT = 2'd2, C_QUIET = 2'd3;

  // Vector layout: {requirement[3:0], kind[1:0], byte[7:0], check[1:0], expected[10:0]}
  localparam logic [26:0] VEC [NVEC] = '{
    {4'd3, K_CMD, 8'hB2, C_NONE, 11'd0},   // R3 page 2
    {4'd2, K_CMD, 8'h05, C_NONE, 11'd0},   // R2 low nibble
    {4'd2, K_CMD, 8'h11, C_NONE, 11'd0},   // R2 high nibble -> column 21
    {4'd4, K_WR,  8'hA5, C_ACC,  11'd285}, // R4 2*132+21
    {4'd5, K_WR,  8'h3C, C_ACC,  11'd286}, // R5 advanced
    {4'd2, K_CMD, 8'h05, C_NONE, 11'd0},   // R2 only low nibble: 23 -> 21
    {4'd6, K_RD,  8'h00, C_DAT,  11'h000}, // R6 dummy read returns 0x00
    {4'd6, K_RD,  8'h00, C_DAT,  11'h0A5}, // R6 lags one address
    {4'd6, K_RD,  8'h00, C_DAT,  11'h03C},
    {4'd5, K_RD,  8'h00, C_ACC,  11'd288}, // R5 reads advance
    {4'd2, K_CMD, 8'h05, C_NONE, 11'd0},
    {4'd7, K_CMD, 8'hE0, C_NONE, 11'd0},   // R7 enter mode at 21
    {4'd7, K_RD,  8'h00, C_ACC,  11'd285},
    {4'd7, K_RD,  8'h00, C_ACC,  11'd285}, // R7 read did not move column
    {4'd7, K_RD,  8'h00, C_DAT,  11'h0A5},
    {4'd7, K_WR,  8'h77, C_ACC,  11'd285},
    {4'd7, K_WR,  8'h66, C_ACC,  11'd286}, // R7 write advanced
    {4'd8, K_CMD, 8'hEE, C_NONE, 11'd0},   // R8 restore to 21
    {4'd8, K_WR,  8'h11, C_ACC,  11'd285},
    {4'd8, K_CMD, 8'hEE, C_NONE, 11'd0},   // R8 outside mode: no effect
    {4'd8, K_WR,  8'h22, C_ACC,  11'd286},
    {4'd3, K_CMD, 8'hB0, C_NONE, 11'd0},
    {4'd2, K_CMD, 8'h00, C_NONE, 11'd0},
    {4'd2, K_CMD, 8'h10, C_NONE, 11'd0},
    {4'd4, K_WR,  8'h5A, C_ACC,  11'd0},
    {4'd9, K_CMD, 8'hA1, C_NONE, 11'd0},   // R9 mirror on
    {4'd2, K_CMD, 8'h00, C_NONE, 11'd0},
    {4'd9, K_WR,  8'hC3, C_ACC,  11'd131},
    {4'd2, K_CMD, 8'h03, C_NONE, 11'd0},
    {4'd2, K_CMD, 8'h18, C_NONE, 11'd0},   // column 131
    {4'd9, K_WR,  8'hD4, C_ACC,  11'd0},
    {4'd5, K_WR,  8'hE5, C_ACC,  11'd0},   // R5 saturated at 131
    {4'd9, K_CMD, 8'hA0, C_NONE, 11'd0},
    {4'd5, K_WR,  8'hF6, C_ACC,  11'd131},
    {4'd11, K_CMD, 8'h40, C_NONE, 11'd0},  // R11 unrelated codes
    {4'd11, K_CMD, 8'h81, C_NONE, 11'd0},
    {4'd11, K_CMD, 8'hA7, C_NONE, 11'd0},
    {4'd11, K_WR,  8'h99, C_ACC,  11'd131},
    {4'd2, K_CMD, 8'h04, C_NONE, 11'd0},   // column 132
    {4'd10, K_WR, 8'h12, C_QUIET, 11'd0},  // R10 ignored
    {4'd10, K_RD, 8'h00, C_QUIET, 11'd0},
    {4'd10, K_RD, 8'h00, C_DAT,  11'h0A5},
    {4'd3, K_CMD, 8'hB2, C_NONE, 11'd0},
    {4'd2, K_CMD, 8'h05, C_NONE, 11'd0},
    {4'd2, K_CMD, 8'h11, C_NONE, 11'd0},
    {4'd6, K_RD,  8'h00, C_DAT,  11'h0A5}, // R6 stale holder
    {4'd6, K_RD,  8'h00, C_DAT,  11'h011},
    {4'd6, K_RD,  8'h00, C_DAT,  11'h022},
    {4'd3, K_CMD, 8'hB0, C_NONE, 11'd0},
    {4'd2, K_CMD, 8'h00, C_NONE, 11'd0},
    {4'd2, K_CMD, 8'h10, C_NONE, 11'd0},
    {4'd6, K_RD,  8'h00, C_NONE, 11'd0},
    {4'd4, K_RD,  8'h00, C_DAT,  11'h0E5},
    {4'd9, K_CMD, 8'hA1, C_NONE, 11'd0},
    {4'd2, K_CMD, 8'h00, C_NONE, 11'd0},
    {4'd9, K_RD,  8'h00, C_NONE, 11'd0},
    {4'd9, K_RD,  8'h00, C_DAT,  11'h099}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_stb = 1'b0, wr_stb = 1'b0, rd_stb = 1'b0;
  logic [7:0]  din = '0;
  logic [10:0] mem_addr;
  logic        mem_we, mem_re;
  logic [7:0]  rd_data;
  int          n_cmp = 0, n_bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  disp_ram_access dut_i (
    .clk(clk), .rst(rst), .cmd_stb(cmd_stb), .wr_stb(wr_stb), .rd_stb(rd_stb),
    .din(din), .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re), .rd_data(rd_data)
  );

  task automatic check(input logic ok, input int req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL R%0d: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic apply(input logic [1:0] kind, input logic [7:0] b);
    @(negedge clk);
    din     = b;
    cmd_stb = (kind == K_CMD);
    wr_stb  = (kind == K_WR);
    rd_stb  = (kind == K_RD);
    @(negedge clk);
    cmd_stb = 1'b0;
    wr_stb  = 1'b0;
    rd_stb  = 1'b0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state at the ports
    check(rd_data == 8'h00 && !mem_we && !mem_re && mem_addr == 11'd0, 1,
          {mem_we, mem_re, rd_data}, 0);

    for (int i = 0; i < NVEC; i++) begin
      logic [3:0]  req;
      logic [1:0]  kind, chk;
      logic [7:0]  b;
      logic [10:0] exp;
      {req, kind, b, chk, exp} = VEC[i];
      apply(kind, b);
      if (chk == C_ACC) begin
        if (kind == K_WR)
          check(mem_we && mem_addr == exp, int'(req), int'(mem_addr), int'(exp));
        else
          check(mem_re && mem_addr == exp, int'(req), int'(mem_addr), int'(exp));
      end else if (chk == C_QUIET) begin
        check(!mem_we && !mem_re, int'(req), {mem_we, mem_re}, 0);
      end else if (chk == C_DAT) begin
        @(negedge clk);
        check(rd_data == exp[7:0], int'(req), int'(rd_data), int'(exp[7:0]));
      end
    end

    // R1 reset in mid-run: mirror was on, so a write must land at column 0 unmirrored
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(rd_data == 8'h00 && !mem_we && !mem_re, 1, int'(rd_data), 0);
    apply(K_WR, 8'h01);
    check(mem_we && mem_addr == 11'd0, 1, int'(mem_addr), 0);
    apply(K_WR, 8'h02);
    check(mem_we && mem_addr == 11'd1, 5, int'(mem_addr), 1);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule